// File: doc/BRIEF.md
# Configuration Window Mapper

This block decides, for a device with six base address registers and one expansion-ROM register, which address windows are live and where they sit. Each region has a fixed size (a power of two, or zero for an absent region) and a fixed space, I/O or memory, set by parameters. The ROM region is always memory space. The live command word and the raw register contents arrive on ports. When the update strobe is pulsed, the block evaluates every region against its enable bits and the window sanity rules, and keeps the result as a candidate set.

A small sequencer then reconciles the latched mapping with the candidates. It handles one region per cycle, lowest index first. A region whose base has moved is first withdrawn with an unmap pulse, if it was live, and is then installed with a map pulse, if the new window is legal. Each pulse carries the index of its region. Downstream address routing can follow these pulses to tear down and rebuild its own decode.

The latched windows also feed a combinational hit decoder. For an incoming address and access space, it reports whether a live window of that space covers the address, and which region it is. The lowest region index wins when windows overlap.

Top module: `bar_window_map`

## Requirements
- R1: An I/O region can be live only while command bit 0 is set, and a memory region (including the ROM) only while command bit 1 is set; otherwise the region is unmapped.
- R2: A live region's base is its register value with the low log2(size) bits cleared, and its limit is base + size − 1; an unmapped region shows base 0 and limit 0.
- R3: An I/O window is rejected when its limit is not greater than its base, when its base is zero, or when its limit is 0x10000 or above.
- R4: A memory window is rejected when its limit is not greater than its base, when its base is zero, or when its limit is all ones.
- R5: The ROM region (index 6) is unmapped whenever bit 0 of its register is 0, regardless of the command word; bit 0 is not part of the base.
- R6: A region whose size parameter is zero is never mapped.
- R7: After reset every region is unmapped, no pulse is active and no hit is reported.
- R8: After an update, a region produces activity only if its new effective mapping differs from the latched one. Such a region gets an unmap pulse if it was live, then a map pulse on a later cycle if the new window is legal. Regions are handled in ascending index order, with at most one pulse per cycle, each pulse one cycle wide and carrying the region index.
- R9: Changes to the command word or the register values have no effect on the outputs until the update strobe is pulsed.
- R10: The hit output is asserted when a latched live region of the requested space (access_io 1 = I/O, 0 = memory) covers the address, bounds inclusive. The hit index is the lowest such region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_i | input | 1 | Update strobe: capture a new candidate mapping |
| cmd_i | input | 16 | Command word; bit 0 enables I/O, bit 1 enables memory |
| bar_i | input | 7*ADDR_W | Raw register words, region 0 in the low bits, ROM highest |
| hit_addr_i | input | ADDR_W | Address to decode |
| hit_io_i | input | 1 | Access space of the decoded address, 1 = I/O |
| win_valid_o | output | 7 | Latched live flag per region |
| win_base_o | output | 7*ADDR_W | Latched base per region |
| win_limit_o | output | 7*ADDR_W | Latched inclusive limit per region |
| unmap_o | output | 1 | One-cycle pulse: a region was withdrawn |
| unmap_idx_o | output | 3 | Index of the withdrawn region |
| map_o | output | 1 | One-cycle pulse: a region was installed |
| map_idx_o | output | 3 | Index of the installed region |
| hit_o | output | 1 | Address falls in a live window of the requested space |
| hit_idx_o | output | 3 | Winning region index |

## Verification
The bench builds the block with 32-bit addresses and a mixed region set: two I/O regions of 16 and 256 bytes, memory regions of 4 KiB and 1 MiB, an absent region, a one-byte memory region that can never be legal, and a 2 KiB ROM. With these values, one sweep over a short list of register patterns and all four enable combinations reaches every rejection rule. The patterns include the 64K port ceiling, the top of the memory space, a zero base and the ROM enable bit. The same sweep makes overlapping windows of both spaces, so the priority of the hit decoder is exercised, and it moves the bases in a way that produces unmap-only, map-only and unmap-then-map sequences.

// File: rtl/bwv_pkg.sv
// Package bwv_pkg
// Shared constants for the window mapper: which command bits enable which
// space, where the ROM enable bit lives, and the access-space encoding.
package bwv_pkg;
    localparam int CMD_IO_EN_BIT  = 0;
    localparam int CMD_MEM_EN_BIT = 1;
    localparam int ROM_EN_BIT     = 0;

    typedef enum logic {
        SPACE_MEM = 1'b0,
        SPACE_IO  = 1'b1
    } space_e;
endpackage

// File: rtl/bwv_region_eval.sv
// Module bwv_region_eval
// Purely combinational evaluation of one region: masks the raw register
// word down to the window base and applies the legality rules.
// Assumes SIZE is zero or a power of two. A zero SIZE means the region
// is absent, and then the region is never legal.
module bwv_region_eval
    import bwv_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              IO_LIMIT_W = 16,
    parameter logic [ADDR_W-1:0] SIZE     = '0,
    parameter bit              IS_IO      = 1'b0,
    parameter bit              IS_ROM     = 1'b0
) (
    input  logic [15:0]       cmd_i,
    input  logic [ADDR_W-1:0] raw_i,
    output logic              legal_o,
    output logic [ADDR_W-1:0] base_o
);
    localparam logic [ADDR_W-1:0] SPAN = SIZE - 1'b1;

    generate
        if (SIZE == '0) begin : g_absent
            // Absent region: never mapped.
            always_comb begin
                legal_o = 1'b0;
                base_o  = '0;
            end
        end else begin : g_present
            logic [ADDR_W-1:0] masked;
            logic [ADDR_W-1:0] last;
            logic              space_en;
            logic              shape_ok;
            logic              range_ok;

            // Masked base and inclusive end of the candidate window.
            always_comb begin
                masked = raw_i & ~SPAN;
                last   = masked + SPAN;
            end

            // Enable gating: command bit per space, plus ROM enable bit.
            always_comb begin
                if (IS_IO) begin
                    space_en = cmd_i[CMD_IO_EN_BIT];
                end else if (IS_ROM) begin
                    space_en = cmd_i[CMD_MEM_EN_BIT] & raw_i[ROM_EN_BIT];
                end else begin
                    space_en = cmd_i[CMD_MEM_EN_BIT];
                end
            end

            // Window shape rules common to both spaces.
            always_comb shape_ok = (last > masked) && (masked != '0);

            // Space-specific ceiling check.
            always_comb begin
                if (IS_IO) begin
                    range_ok = ((last >> IO_LIMIT_W) == '0);
                end else begin
                    range_ok = (last != '1);
                end
            end

            // Final verdict; an illegal window reports base zero.
            always_comb begin
                legal_o = space_en & shape_ok & range_ok;
                base_o  = legal_o ? masked : '0;
            end
        end
    endgenerate
endmodule

// File: rtl/bwv_sequencer.sv
// Module bwv_sequencer
// Holds the candidate set captured on each update strobe and the latched
// mapping. Each cycle it retires one differing region, lowest index first:
// a live region is withdrawn (unmap pulse), and a dead region that should
// be live is installed (map pulse). An update strobe takes priority over
// retirement in its cycle, and then no pulse is issued in that cycle.
// Assumes base is zero whenever the region is not legal.
module bwv_sequencer #(
    parameter int NREG   = 7,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd_i,
    input  logic [NREG-1:0]        cand_legal_i,
    input  logic [NREG*ADDR_W-1:0] cand_base_i,
    output logic [NREG-1:0]        cur_valid_o,
    output logic [NREG*ADDR_W-1:0] cur_base_o,
    output logic                   unmap_o,
    output logic [IDX_W-1:0]       unmap_idx_o,
    output logic                   map_o,
    output logic [IDX_W-1:0]       map_idx_o
);
    logic [NREG-1:0]   snap_valid;
    logic [ADDR_W-1:0] snap_base [NREG];
    logic [NREG-1:0]   cur_valid;
    logic [ADDR_W-1:0] cur_base  [NREG];
    logic [NREG-1:0]   pend;
    logic              any_pend;
    logic [IDX_W-1:0]  sel;

    // Per-region mismatch between candidate and latched mapping.
    for (genvar gi = 0; gi < NREG; gi++) begin : g_pend
        assign pend[gi] = (snap_valid[gi] != cur_valid[gi]) ||
                          (snap_base[gi] != cur_base[gi]);
        assign cur_base_o[gi*ADDR_W +: ADDR_W] = cur_base[gi];
    end

    assign cur_valid_o = cur_valid;

    // Lowest-index pending region.
    always_comb begin
        any_pend = 1'b0;
        sel      = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any_pend = 1'b1;
                sel      = IDX_W'(i);
            end
        end
    end

    // Capture candidates on update; otherwise retire one pending region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_valid  <= '0;
            cur_valid   <= '0;
            unmap_o     <= 1'b0;
            map_o       <= 1'b0;
            unmap_idx_o <= '0;
            map_idx_o   <= '0;
            for (int i = 0; i < NREG; i++) begin
                snap_base[i] <= '0;
                cur_base[i]  <= '0;
            end
        end else begin
            unmap_o <= 1'b0;
            map_o   <= 1'b0;
            if (upd_i) begin
                snap_valid <= cand_legal_i;
                for (int i = 0; i < NREG; i++) begin
                    snap_base[i] <= cand_base_i[i*ADDR_W +: ADDR_W];
                end
            end else if (any_pend) begin
                if (cur_valid[sel]) begin
                    cur_valid[sel] <= 1'b0;
                    cur_base[sel]  <= '0;
                    unmap_o        <= 1'b1;
                    unmap_idx_o    <= sel;
                end else begin
                    cur_valid[sel] <= 1'b1;
                    cur_base[sel]  <= snap_base[sel];
                    map_o          <= 1'b1;
                    map_idx_o      <= sel;
                end
            end
        end
    end
endmodule

// File: rtl/bwv_hit_decode.sv
// Module bwv_hit_decode
// Combinational address decode against the latched windows. A region hits
// when it is live, its space matches the access space and the address lies
// within base..limit inclusive. The lowest index wins.
// Assumes limit is at or above base for every live region.
module bwv_hit_decode #(
    parameter int            NREG   = 7,
    parameter int            ADDR_W = 32,
    parameter int            IDX_W  = 3,
    parameter logic [NREG-1:0] SPACE_IO = '0
) (
    input  logic [NREG-1:0]        valid_i,
    input  logic [NREG*ADDR_W-1:0] base_i,
    input  logic [NREG*ADDR_W-1:0] limit_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   io_i,
    output logic                   hit_o,
    output logic [IDX_W-1:0]       idx_o
);
    logic [NREG-1:0] match;

    // Per-region range and space comparison.
    for (genvar gi = 0; gi < NREG; gi++) begin : g_match
        assign match[gi] = valid_i[gi] && (SPACE_IO[gi] == io_i) &&
                           (addr_i >= base_i[gi*ADDR_W +: ADDR_W]) &&
                           (addr_i <= limit_i[gi*ADDR_W +: ADDR_W]);
    end

    // Priority select, lowest index first.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/bar_window_map.sv
// Module bar_window_map
// Top of the window mapper: evaluates the NUM_BARS base registers plus the
// ROM register (highest index), sequences map and unmap events against the
// latched mapping, and decodes incoming addresses.
// Assumes the region sizes are zero or powers of two. The ROM region is
// always memory space, so its REG_IS_IO bit is ignored.
module bar_window_map
    import bwv_pkg::*;
#(
    parameter int NUM_BARS   = 6,
    parameter int ADDR_W     = 32,
    parameter int IO_LIMIT_W = 16,
    parameter logic [(NUM_BARS+1)*ADDR_W-1:0] REG_SIZES =
        {32'h0000_0800, 32'h0010_0000, 32'h0000_0001, 32'h0000_0100,
         32'h0000_0000, 32'h0000_1000, 32'h0000_0010},
    parameter logic [NUM_BARS:0] REG_IS_IO = 7'b000_1001,
    localparam int NREG  = NUM_BARS + 1,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd_i,
    input  logic [15:0]            cmd_i,
    input  logic [NREG*ADDR_W-1:0] bar_i,
    input  logic [ADDR_W-1:0]      hit_addr_i,
    input  logic                   hit_io_i,
    output logic [NREG-1:0]        win_valid_o,
    output logic [NREG*ADDR_W-1:0] win_base_o,
    output logic [NREG*ADDR_W-1:0] win_limit_o,
    output logic                   unmap_o,
    output logic [IDX_W-1:0]       unmap_idx_o,
    output logic                   map_o,
    output logic [IDX_W-1:0]       map_idx_o,
    output logic                   hit_o,
    output logic [IDX_W-1:0]       hit_idx_o
);
    localparam int ROM_IDX = NUM_BARS;
    localparam logic [NREG-1:0] SPACE_IO = {1'b0, REG_IS_IO[NUM_BARS-1:0]};

    logic [NREG-1:0]        cand_legal;
    logic [NREG*ADDR_W-1:0] cand_base;

    // One evaluator per region; the ROM variant is picked by index.
    for (genvar gi = 0; gi < NREG; gi++) begin : g_region
        localparam logic [ADDR_W-1:0] SZ = REG_SIZES[gi*ADDR_W +: ADDR_W];

        bwv_region_eval #(
            .ADDR_W     (ADDR_W),
            .IO_LIMIT_W (IO_LIMIT_W),
            .SIZE       (SZ),
            .IS_IO      (SPACE_IO[gi]),
            .IS_ROM     (gi == ROM_IDX)
        ) eval_i (
            .cmd_i   (cmd_i),
            .raw_i   (bar_i[gi*ADDR_W +: ADDR_W]),
            .legal_o (cand_legal[gi]),
            .base_o  (cand_base[gi*ADDR_W +: ADDR_W])
        );

        // Limit follows the latched base; zero when the region is down.
        assign win_limit_o[gi*ADDR_W +: ADDR_W] = win_valid_o[gi] ?
            win_base_o[gi*ADDR_W +: ADDR_W] + SZ - 1'b1 : '0;
    end

    bwv_sequencer #(
        .NREG   (NREG),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .upd_i        (upd_i),
        .cand_legal_i (cand_legal),
        .cand_base_i  (cand_base),
        .cur_valid_o  (win_valid_o),
        .cur_base_o   (win_base_o),
        .unmap_o      (unmap_o),
        .unmap_idx_o  (unmap_idx_o),
        .map_o        (map_o),
        .map_idx_o    (map_idx_o)
    );

    bwv_hit_decode #(
        .NREG     (NREG),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .SPACE_IO (SPACE_IO)
    ) hit_i (
        .valid_i (win_valid_o),
        .base_i  (win_base_o),
        .limit_i (win_limit_o),
        .addr_i  (hit_addr_i),
        .io_i    (hit_io_i),
        .hit_o   (hit_o),
        .idx_o   (hit_idx_o)
    );
endmodule

// File: rtl/bar_window_map_chk.sv
// Module bar_window_map_chk
// Property checker bound to bar_window_map. It watches only ports.
module bar_window_map_chk #(
    parameter int NUM_BARS   = 6,
    parameter int ADDR_W     = 32,
    parameter int IO_LIMIT_W = 16,
    parameter logic [(NUM_BARS+1)*ADDR_W-1:0] REG_SIZES = '0,
    parameter logic [NUM_BARS:0] REG_IS_IO = '0,
    localparam int NREG  = NUM_BARS + 1,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   upd_i,
    input logic [NREG-1:0]        win_valid_o,
    input logic [NREG*ADDR_W-1:0] win_base_o,
    input logic [NREG*ADDR_W-1:0] win_limit_o,
    input logic                   unmap_o,
    input logic [IDX_W-1:0]       unmap_idx_o,
    input logic                   map_o,
    input logic [IDX_W-1:0]       map_idx_o,
    input logic                   hit_o,
    input logic [IDX_W-1:0]       hit_idx_o
);
    // R8: one pulse per cycle at most.
    assert_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(unmap_o && map_o));

    // R8: an unmap pulse names a region that was live and is now down.
    assert_unmap_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unmap_o |-> (!win_valid_o[unmap_idx_o] && (($past(win_valid_o) >> unmap_idx_o) & 1) == 1));

    // R8: a map pulse names a region that was down and is now live.
    assert_map_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        map_o |-> (win_valid_o[map_idx_o] && (($past(win_valid_o) >> map_idx_o) & 1) == 0));

    // R9: the latched mapping moves only alongside a pulse.
    assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!unmap_o && !map_o) |-> ($stable(win_valid_o) && $stable(win_base_o)));

    // R8: the cycle of an update strobe is followed by a quiet cycle.
    assert_strobe_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> (!unmap_o && !map_o));

    // R10: a hit always names a live region.
    assert_hit_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> win_valid_o[hit_idx_o]);

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        localparam logic [ADDR_W-1:0] SZ = REG_SIZES[gi*ADDR_W +: ADDR_W];
        if (SZ == '0) begin : g_absent
            // R6: absent regions never come up.
            assert_absent_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !win_valid_o[gi]);
        end else begin : g_present
            // R2: live window spans exactly its size.
            assert_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
                win_valid_o[gi] |-> ((win_limit_o[gi*ADDR_W +: ADDR_W] -
                    win_base_o[gi*ADDR_W +: ADDR_W]) == SZ - 1'b1));
            if (gi < NUM_BARS && REG_IS_IO[gi]) begin : g_io
                // R3: live I/O windows stay under the port ceiling.
                assert_io_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    win_valid_o[gi] |-> (((win_limit_o[gi*ADDR_W +: ADDR_W] >> IO_LIMIT_W) == '0) &&
                        (win_base_o[gi*ADDR_W +: ADDR_W] != '0)));
            end else begin : g_mem
                // R4: live memory windows never reach the all-ones address.
                assert_mem_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    win_valid_o[gi] |-> ((win_limit_o[gi*ADDR_W +: ADDR_W] != '1) &&
                        (win_base_o[gi*ADDR_W +: ADDR_W] != '0)));
            end
        end
    end
endmodule

bind bar_window_map bar_window_map_chk #(
    .NUM_BARS   (NUM_BARS),
    .ADDR_W     (ADDR_W),
    .IO_LIMIT_W (IO_LIMIT_W),
    .REG_SIZES  (REG_SIZES),
    .REG_IS_IO  (REG_IS_IO)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_i       (upd_i),
    .win_valid_o (win_valid_o),
    .win_base_o  (win_base_o),
    .win_limit_o (win_limit_o),
    .unmap_o     (unmap_o),
    .unmap_idx_o (unmap_idx_o),
    .map_o       (map_o),
    .map_idx_o   (map_idx_o),
    .hit_o       (hit_o),
    .hit_idx_o   (hit_idx_o)
);

// File: tb/bar_window_map_tb_top.sv
// Bench for bar_window_map: sweeps register patterns against all command
// enables, checks windows, pulse order and hit decode against a model.
module bar_window_map_tb_top;
    localparam int NB = 6;
    localparam int NR = 7;
    localparam int AW = 32;
    localparam logic [NR*AW-1:0] TB_SIZES =
        {32'h0000_0800, 32'h0010_0000, 32'h0000_0001, 32'h0000_0100,
         32'h0000_0000, 32'h0000_1000, 32'h0000_0010};
    localparam logic [NB:0] TB_IO = 7'b000_1001;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           upd_i = 1'b0;
    logic [15:0]    cmd_i = '0;
    logic [NR*AW-1:0] bar_i = '0;
    logic [AW-1:0]  hit_addr_i = '0;
    logic           hit_io_i = 1'b0;
    logic [NR-1:0]  win_valid_o;
    logic [NR*AW-1:0] win_base_o;
    logic [NR*AW-1:0] win_limit_o;
    logic           unmap_o, map_o, hit_o;
    logic [2:0]     unmap_idx_o, map_idx_o, hit_idx_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic          exp_v [NR];
    logic [AW-1:0] exp_b [NR];

    always #5 clk = ~clk;

    bar_window_map #(
        .NUM_BARS (NB), .ADDR_W (AW), .IO_LIMIT_W (16),
        .REG_SIZES (TB_SIZES), .REG_IS_IO (TB_IO)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .upd_i (upd_i), .cmd_i (cmd_i),
        .bar_i (bar_i), .hit_addr_i (hit_addr_i), .hit_io_i (hit_io_i),
        .win_valid_o (win_valid_o), .win_base_o (win_base_o),
        .win_limit_o (win_limit_o), .unmap_o (unmap_o),
        .unmap_idx_o (unmap_idx_o), .map_o (map_o), .map_idx_o (map_idx_o),
        .hit_o (hit_o), .hit_idx_o (hit_idx_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] size_of(input int i);
        return TB_SIZES[i*AW +: AW];
    endfunction

    function automatic bit is_io(input int i);
        return (i < NB) && TB_IO[i];
    endfunction

    // Reference evaluation of one region; tag names the deciding rule.
    function automatic void model(input int i, input logic [15:0] cmd,
                                  input logic [AW-1:0] raw, output logic v,
                                  output logic [AW-1:0] b, output string tag);
        logic [AW-1:0] sz, base, last;
        sz = size_of(i);
        v = 1'b0;
        b = '0;
        if (sz == 0) begin
            tag = "R6";
        end else if (is_io(i) ? !cmd[0] : !cmd[1]) begin
            tag = "R1";
        end else if (i == NB && !raw[0]) begin
            tag = "R5";
        end else begin
            base = raw & ~(sz - 1);
            last = base + sz - 1;
            if (is_io(i)) begin
                tag = "R3";
                if (!(last <= base || base == 0 || last >= 32'h1_0000)) begin
                    v = 1'b1;
                end
            end else begin
                tag = "R4";
                if (!(last <= base || base == 0 || last == 32'hFFFF_FFFF)) begin
                    v = 1'b1;
                end
            end
            if (v) begin
                b = base;
                tag = "R2";
            end
        end
    endfunction

    // Register pattern k for region i; chosen to hit each rejection rule.
    function automatic logic [AW-1:0] pattern(input int i, input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_FFF1;
            2: return 32'h0001_0000;
            3: return 32'hFFFF_F001;
            4: return 32'h000C_0001 + AW'(i) * 32'h0010_0000;
            5: return 32'h2000_0001;
            default: return 32'h0000_C000 | AW'(i & 1);
        endcase
    endfunction

    // Compare every output window with the model's latched state.
    task automatic check_windows(input string ctx);
        for (int i = 0; i < NR; i++) begin
            logic [AW-1:0] el;
            el = exp_v[i] ? exp_b[i] + size_of(i) - 1 : '0;
            check(win_valid_o[i] == exp_v[i], "R7", $sformatf("%s valid[%0d]", ctx, i),
                  AW'(win_valid_o[i]), AW'(exp_v[i]));
            check(win_base_o[i*AW +: AW] == exp_b[i], "R2", $sformatf("%s base[%0d]", ctx, i),
                  win_base_o[i*AW +: AW], exp_b[i]);
            check(win_limit_o[i*AW +: AW] == el, "R2", $sformatf("%s limit[%0d]", ctx, i),
                  win_limit_o[i*AW +: AW], el);
        end
    endtask

    // Probe one address in one space against the model's priority scan.
    task automatic probe(input logic [AW-1:0] a, input bit io);
        bit      eh = 1'b0;
        int      ei = 0;
        for (int i = NR - 1; i >= 0; i--) begin
            if (exp_v[i] && is_io(i) == io && a >= exp_b[i] &&
                a <= exp_b[i] + size_of(i) - 1) begin
                eh = 1'b1;
                ei = i;
            end
        end
        hit_addr_i = a;
        hit_io_i = io;
        #1;
        check(hit_o == eh, "R10", $sformatf("hit @%h io=%0d", a, io), AW'(hit_o), AW'(eh));
        if (eh) begin
            check(hit_idx_o == 3'(ei), "R10", $sformatf("hit idx @%h", a),
                  AW'(hit_idx_o), AW'(ei));
        end
    endtask

    // Strobe an update, record pulses, compare order and final windows.
    task automatic do_update(input logic [15:0] cmd, input logic [NR*AW-1:0] bars);
        int   log_q [32];
        int   exp_q [32];
        int   nlog = 0;
        int   nexp = 0;
        logic nv [NR];
        logic [AW-1:0] nb [NR];
        string tags [NR];
        @(negedge clk);
        cmd_i = cmd;
        bar_i = bars;
        upd_i = 1'b1;
        @(negedge clk);
        upd_i = 1'b0;
        for (int c = 0; c < 18; c++) begin
            @(negedge clk);
            if (unmap_o && nlog < 32) begin log_q[nlog] = 16 + int'(unmap_idx_o); nlog++; end
            if (map_o && nlog < 32)   begin log_q[nlog] = 32 + int'(map_idx_o);   nlog++; end
        end
        for (int i = 0; i < NR; i++) begin
            model(i, cmd, bars[i*AW +: AW], nv[i], nb[i], tags[i]);
            if (nv[i] != exp_v[i] || nb[i] != exp_b[i]) begin
                if (exp_v[i]) begin exp_q[nexp] = 16 + i; nexp++; end
                if (nv[i])    begin exp_q[nexp] = 32 + i; nexp++; end
            end
        end
        check(nlog == nexp, "R8", "pulse count", AW'(nlog), AW'(nexp));
        for (int j = 0; j < nexp && j < nlog; j++) begin
            check(log_q[j] == exp_q[j], "R8", $sformatf("pulse %0d kind/idx", j),
                  AW'(log_q[j]), AW'(exp_q[j]));
        end
        for (int i = 0; i < NR; i++) begin
            exp_v[i] = nv[i];
            exp_b[i] = nb[i];
            check(win_valid_o[i] == nv[i], tags[i], $sformatf("cmd=%0h region %0d valid", cmd, i),
                  AW'(win_valid_o[i]), AW'(nv[i]));
        end
        check_windows("update");
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin exp_v[i] = 1'b0; exp_b[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state.
        check(!unmap_o && !map_o, "R7", "no pulse after reset", AW'({unmap_o, map_o}), '0);
        check_windows("reset");
        probe(32'h0000_C000, 1'b1);
        probe(32'h2000_0000, 1'b0);

        for (int s = 0; s < 14; s++) begin
            for (int c = 0; c < 4; c++) begin
                logic [NR*AW-1:0] bars;
                for (int i = 0; i < NR; i++) begin
                    bars[i*AW +: AW] = pattern(i, (s + i * 3 + c) % 7);
                end
                do_update(16'(c), bars);
                for (int i = 0; i < NR; i++) begin
                    if (exp_v[i]) begin
                        for (int io = 0; io < 2; io++) begin
                            probe(exp_b[i], io[0]);
                            probe(exp_b[i] + size_of(i) - 1, io[0]);
                            probe(exp_b[i] + size_of(i), io[0]);
                            probe(exp_b[i] - 1, io[0]);
                        end
                    end
                end
            end
        end

        // R9: inputs moved without a strobe leave everything as it was.
        begin
            int pulses = 0;
            @(negedge clk);
            cmd_i = ~cmd_i;
            bar_i = ~bar_i;
            for (int c = 0; c < 18; c++) begin
                @(negedge clk);
                if (unmap_o || map_o) pulses++;
            end
            check(pulses == 0, "R9", "pulses without strobe", AW'(pulses), '0);
            check_windows("R9 hold");
        end

        // R8: repeating the same update is silent.
        begin
            logic [NR*AW-1:0] same;
            for (int i = 0; i < NR; i++) same[i*AW +: AW] = pattern(i, 6);
            do_update(16'h3, same);
            do_update(16'h3, same);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule